// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block performs the tag lookup of a two-way set-associative cache using a single tag comparator. Every set keeps one guess bit naming the way to probe first. A request compares only the guessed way's tag. If that compare fails, the block spends one more cycle comparing the other way of the same set. Each lookup ends in one of three results: a fast hit (the guess was right), a slow hit (the other way matched) or a miss (neither way matched).

A fill port writes a tag and a data word into a chosen way of a set. It marks that entry valid and points the set's guess at the filled way. Picking a victim and fetching lines from memory belong to the surrounding cache controller. The address splits into a set index in its low `SET_W` bits and a tag in the bits above them. The reset input is asynchronous and active low, and the block releases it through a two-flop synchronizer.

Top module: `wp_lookup`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0, `rsp_kind` is 0 and `req_ready` is 1. After reset every entry is invalid and every set guesses way 0.
- R2: When the guessed way holds a valid matching tag, the response appears on the clock edge that accepts the request. It carries `rsp_kind` = 1 (fast hit), the hit way and that entry's data.
- R3: When the guessed way does not match and the other way holds a valid matching tag, the response appears one edge after acceptance. It carries `rsp_kind` = 2 (slow hit), the other way and its data.
- R4: When neither way matches, the response appears one edge after acceptance with `rsp_kind` = 3 (miss), `rsp_way` = 0 and `rsp_data` = 0.
- R5: A slow hit changes the set's guess to the way that hit. A fast hit or a miss leaves the guess unchanged.
- R6: A fill writes the tag and data into the selected way and marks the entry valid. It also points that set's guess at the filled way, and it overwrites whatever the entry held before.
- R7: An entry whose valid bit is clear never matches, whatever its tag bits hold.
- R8: `req_ready` is 0 during the second probe cycle. A request presented in that cycle is ignored and produces no response.
- R9: Guesses are per set, so a fill or a slow hit in one set does not change the probe order of another set.
- R10: When no response is presented, `rsp_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address: set index in the low bits, tag above them |
| req_ready | output | 1 | The block can accept a request this cycle |
| fill_valid | input | 1 | Install an entry |
| fill_addr | input | ADDR_W | Address whose set and tag are installed |
| fill_way | input | 1 | Way to write |
| fill_data | input | DATA_W | Data word to install |
| rsp_valid | output | 1 | Result present for one cycle |
| rsp_kind | output | 2 | 0 none, 1 fast hit, 2 slow hit, 3 miss |
| rsp_way | output | 1 | Way that hit (0 on a miss) |
| rsp_data | output | DATA_W | Data of the hitting entry (0 on a miss) |

## Verification
The assertions check on every cycle that:
- a matching first probe yields a fast result on the next edge;
- a second probe always ends, one edge later, in a slow hit or a miss, and the busy phase never lasts longer than that;
- a miss carries zero way and data;
- a slow hit leaves its set's guess on the hitting way.

The bench's scenarios are needed to show behaviour that depends on history:
- the guess a fill installs, and a fast hit following a slow one;
- sets staying independent of each other;
- invalid entries staying silent;
- overwritten tags no longer matching;
- requests offered while the block is busy disappearing without a response.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_FAST = 2'd1,
    K_SLOW = 2'd2,
    K_MISS = 2'd3
  } kind_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } probe_st_e;
endpackage

// File: rtl/wp_way_store.sv
module wp_way_store #(
  parameter int SET_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SET_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [SETS-1:0]   valid_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
  parameter int SET_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic [SET_W-1:0]   fill_idx,
  input  logic               fill_way,
  input  logic               upd_en,
  input  logic [SET_W-1:0]   upd_idx,
  input  logic               upd_way,
  input  logic [SET_W-1:0]   rd_idx,
  output logic               rd_way,
  output logic [(1<<SET_W)-1:0] pred_vec
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] pred_q;
  logic [SETS-1:0] pred_d;

  // a fill to the same set in the same cycle wins over a slow-hit update
  always_comb begin
    pred_d = pred_q;
    if (upd_en)  pred_d[upd_idx]  = upd_way;
    if (fill_en) pred_d[fill_idx] = fill_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pred_q <= '0;
    else        pred_q <= pred_d;
  end

  assign rd_way   = pred_q[rd_idx];
  assign pred_vec = pred_q;
endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
  import wp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_way,
  input  logic [DATA_W-1:0] fill_data,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic              rsp_way,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAYS  = 2;
  localparam int SETS  = 1 << SET_W;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  // probe state
  probe_st_e         state_q, state_d;
  logic [SET_W-1:0]  idx_q, idx_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              first_way_q, first_way_d;

  logic              rsp_valid_q, rsp_valid_d;
  kind_e             rsp_kind_q, rsp_kind_d;
  logic              rsp_way_q, rsp_way_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  logic [SET_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  assign req_idx = req_addr[SET_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:SET_W];

  logic [SET_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;
  assign fill_idx = fill_addr[SET_W-1:0];
  assign fill_tag = fill_addr[ADDR_W-1:SET_W];

  // storage
  logic [SET_W-1:0]  sel_idx;
  logic              way_valid [WAYS];
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [DATA_W-1:0] way_data  [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wp_way_store #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
    ) u_store (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .wr_en   (fill_valid && (fill_way == w[0])),
      .wr_idx  (fill_idx),
      .wr_tag  (fill_tag),
      .wr_data (fill_data),
      .rd_idx  (sel_idx),
      .rd_valid(way_valid[w]),
      .rd_tag  (way_tag[w]),
      .rd_data (way_data[w])
    );
  end

  logic              pred_way;
  logic [SETS-1:0]   pred_vec;
  logic              upd_en;

  wp_pred_table #(.SET_W(SET_W)) u_pred (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .fill_en (fill_valid),
    .fill_idx(fill_idx),
    .fill_way(fill_way),
    .upd_en  (upd_en),
    .upd_idx (idx_q),
    .upd_way (~first_way_q),
    .rd_idx  (req_idx),
    .rd_way  (pred_way),
    .pred_vec(pred_vec)
  );

  // the single comparator, steered by the probe state
  logic             in_second;
  logic             sel_way;
  logic [TAG_W-1:0] cur_tag;
  logic             hit_now;
  logic             accept;

  assign in_second = (state_q == ST_SECOND);
  assign sel_idx   = in_second ? idx_q : req_idx;
  assign sel_way   = in_second ? ~first_way_q : pred_way;
  assign cur_tag   = in_second ? tag_q : req_tag;
  assign hit_now   = way_valid[sel_way] && (way_tag[sel_way] == cur_tag);
  assign req_ready = !in_second;
  assign accept    = req_valid && !in_second;
  assign upd_en    = in_second && hit_now;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    tag_d       = tag_q;
    first_way_d = first_way_q;
    rsp_valid_d = 1'b0;
    rsp_kind_d  = K_NONE;
    rsp_way_d   = 1'b0;
    rsp_data_d  = '0;
    if (in_second) begin
      state_d     = ST_IDLE;
      rsp_valid_d = 1'b1;
      if (hit_now) begin
        rsp_kind_d = K_SLOW;
        rsp_way_d  = sel_way;
        rsp_data_d = way_data[sel_way];
      end else begin
        rsp_kind_d = K_MISS;
      end
    end else if (accept) begin
      idx_d       = req_idx;
      tag_d       = req_tag;
      first_way_d = sel_way;
      if (hit_now) begin
        rsp_valid_d = 1'b1;
        rsp_kind_d  = K_FAST;
        rsp_way_d   = sel_way;
        rsp_data_d  = way_data[sel_way];
      end else begin
        state_d = ST_SECOND;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_kind_q  <= K_NONE;
      rsp_way_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_kind_q  <= rsp_kind_d;
      rsp_way_q   <= rsp_way_d;
      rsp_data_q  <= rsp_data_d;
    end
  end

  // address latch, loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      idx_q       <= '0;
      tag_q       <= '0;
      first_way_q <= 1'b0;
    end else if (accept) begin
      idx_q       <= idx_d;
      tag_q       <= tag_d;
      first_way_q <= first_way_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = rsp_kind_q;
  assign rsp_way   = rsp_way_q;
  assign rsp_data  = rsp_data_q;

  // R2: a matching first probe yields a fast result on the next edge
  a_r2_fast_next_edge: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && hit_now) |=> (rsp_valid && rsp_kind == K_FAST));

  // R3/R4: the second probe always ends one edge later in slow hit or miss
  a_r3_second_resolves: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_second |=> (rsp_valid && (rsp_kind == K_SLOW || rsp_kind == K_MISS)));

  // R4: a miss carries neither way nor data
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && rsp_kind == K_MISS) |-> (rsp_way == 1'b0 && rsp_data == '0));

  // R5: after a slow hit the set's guess points at the way that hit
  a_r5_guess_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && rsp_kind == K_SLOW && !$past(fill_valid)) |-> (pred_vec[idx_q] == rsp_way));

  // R8: the busy phase lasts one cycle only
  a_r8_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    in_second |=> !in_second);

  // R10: no response means kind none
  a_r10_idle_kind: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rsp_valid |-> (rsp_kind == K_NONE));
endmodule

// File: tb/sim_wp_lookup.sv
module sim_wp_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int SET_W  = 3;
  localparam int DATA_W = 16;
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int SETS   = 1 << SET_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              fill_valid;
  logic [ADDR_W-1:0] fill_addr;
  logic              fill_way;
  logic [DATA_W-1:0] fill_data;
  logic              rsp_valid;
  logic [1:0]        rsp_kind;
  logic              rsp_way;
  logic [DATA_W-1:0] rsp_data;

  wp_lookup #(.ADDR_W(ADDR_W), .SET_W(SET_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
    .fill_data(fill_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_way(rsp_way),
    .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit live   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model built from the requirements
  bit              m_valid [2][SETS];
  bit [TAG_W-1:0]  m_tag   [2][SETS];
  bit [DATA_W-1:0] m_data  [2][SETS];
  bit              m_pred  [SETS];

  typedef struct packed {
    logic [1:0]        kind;
    logic              way;
    logic [DATA_W-1:0] data;
    logic [31:0]       when;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per presented response
  always @(negedge clk) begin
    if (live && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected response kind", rsp_kind, 0);
      end else begin
        exp_t  e;
        string rq;
        e  = exp_q.pop_front();
        rq = req_q.pop_front();
        check(rsp_kind == e.kind, rq, "kind", rsp_kind, e.kind);
        check(rsp_way == e.way, rq, "way", rsp_way, e.way);
        check(rsp_data == e.data, rq, "data", rsp_data, e.data);
        check(cyc == int'(e.when), rq, "latency cycle", cyc, e.when);
      end
    end else if (live && !rsp_valid) begin
      if (rsp_kind != 2'd0) check(1'b0, "R10", "kind without response", rsp_kind, 0);
    end
  end

  task automatic fill(input int set, input int tag, input bit way, input int data);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = ADDR_W'((tag << SET_W) | set);
    fill_way   = way;
    fill_data  = DATA_W'(data);
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
    m_valid[way][set] = 1'b1;
    m_tag[way][set]   = TAG_W'(tag);
    m_data[way][set]  = DATA_W'(data);
    m_pred[set]       = way;
  endtask

  // driver: computes the expected result and pushes it
  task automatic lookup(input int set, input int tag, input string rq,
                        input bit poke_busy = 1'b0);
    exp_t e;
    bit   p;
    int   lat;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'((tag << SET_W) | set);
    p = m_pred[set];
    if (m_valid[p][set] && m_tag[p][set] == TAG_W'(tag)) begin
      e.kind = 2'd1; e.way = p; e.data = m_data[p][set]; lat = 1;
    end else if (m_valid[!p][set] && m_tag[!p][set] == TAG_W'(tag)) begin
      e.kind = 2'd2; e.way = !p; e.data = m_data[!p][set]; lat = 2;
      m_pred[set] = !p;
    end else begin
      e.kind = 2'd3; e.way = 1'b0; e.data = '0; lat = 2;
    end
    @(posedge clk);
    #1;
    e.when = 32'(cyc + lat - 1);
    exp_q.push_back(e);
    req_q.push_back(rq);
    req_valid = 1'b0;
    if (poke_busy && lat == 2) begin
      // R8: offer another request while the second probe runs
      @(negedge clk);
      check(req_ready == 1'b0, "R8", "ready during second probe", req_ready, 0);
      req_valid = 1'b1;
      req_addr  = ADDR_W'((tag << SET_W) | ((set + 1) % SETS));
      @(posedge clk);
      #1;
      req_valid = 1'b0;
    end
  endtask

  task automatic drain;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "responses outstanding", exp_q.size(), 0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 1'b0;
      m_valid[0][s] = 1'b0;
      m_valid[1][s] = 1'b0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    fill_valid = 1'b0; fill_addr = '0; fill_way = 1'b0; fill_data = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;
    check(rsp_valid == 1'b0 && rsp_kind == 2'd0, "R1", "idle after reset", rsp_kind, 0);

    // R1 R7: empty cache misses, including tag zero
    lookup(1, 5, "R7");
    lookup(0, 0, "R1");
    // R6 R2: fill way0 then a fast hit
    fill(1, 5, 1'b0, 16'hA5A5);
    lookup(1, 5, "R2");
    // R6: fill way1 moves the guess to way1
    fill(1, 9, 1'b1, 16'h9999);
    lookup(1, 9, "R6");
    // R3 then R5: slow hit flips the guess, the repeat is fast
    lookup(1, 5, "R3");
    lookup(1, 5, "R5");
    lookup(1, 9, "R3");
    lookup(1, 9, "R5");
    // R9: other set filled, set 1 order unchanged
    fill(2, 5, 1'b1, 16'h2222);
    lookup(1, 9, "R9");
    lookup(2, 5, "R9");
    lookup(3, 5, "R4");
    // R8: request during second probe is dropped
    lookup(1, 5, "R8", 1'b1);
    drain();
    // R6: overwrite way0 of set 1, the old tag no longer matches
    fill(1, 12, 1'b0, 16'h0C0C);
    lookup(1, 5, "R4");
    lookup(1, 12, "R6");
    lookup(1, 9, "R3");
    // back-to-back fast hits
    lookup(1, 9, "R2");
    lookup(2, 5, "R2");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule